// File: doc/BRIEF.md
# Capture/Compare Event Channel

This block is one timing event channel that works from either of two free-running timers. In capture mode it watches a single input pin. When the chosen edge arrives it latches the count of the selected timer into a shared time register. A one-deep buffer behind that register holds a second capture. A third capture that arrives while both are occupied is flagged as an overrun, and a control bit then decides whether the new value replaces the buffered one or is dropped. Software collects results by reading the time register. Each read pulls the buffered value forward.

In compare mode the same time register holds a target count. When the selected timer reaches that target, the channel performs its programmed action on an output pin: set, clear, toggle or nothing. It can also ask for the selected timer to be cleared and can pulse an A/D start request. A second, compare-only channel drives the same output pin with its own target, timer choice and action. Neither channel has priority. When both act in the same cycle, their actions are applied one after the other in a fixed order.

Top module: `evch_top`

## Requirements
- R1: After synchronous active-low reset, pin_out is 0, every strobe output is 0, and all four registers (address 0 channel control, 1 channel time, 2 compare-only control, 3 compare-only time) read 0. A written control register reads back its written value: 7 bits at address 0 and 4 bits at address 2, with the upper bits read as zero.
- R2: Channel control bit 0 selects the timer: 0 for tmr_a, 1 for tmr_b. Both captures and compare matches use the selected timer.
- R3: With channel control bit 1 = 0 (capture mode), bits 3:2 select the capture edge: 00 none, 01 falling, 10 rising, 11 both. cap_in passes through a two-flop synchronizer. The timer value present at the third rising clock edge after an input change is the value captured. An edge that is not selected captures nothing and raises no strobe.
- R4: A capture goes into the time register if that register is empty, and otherwise into the buffer. Reading address 1 in capture mode returns the time register. The read moves the buffered value into the time register and empties the buffer. If the buffer is empty, the read empties the time register instead.
- R5: A capture that arrives while the time register and the buffer are both full pulses ovr_irq for one cycle. Control bit 4 = 1 makes the new value replace the buffered one. Control bit 4 = 0 discards the new value.
- R6: evt_irq pulses for exactly one cycle for each accepted capture edge and for each channel compare match.
- R7: With control bit 1 = 1 (compare mode), a match fires in the cycle after the selected timer first equals the time register. A match fires again only after the timer has left that value and returned to it. Bits 3:2 then act on pin_out: 00 none, 01 set, 10 clear, 11 toggle.
- R8: On a channel compare match, control bit 5 = 1 pulses tmr_rst[selected timer] and control bit 6 = 1 pulses adc_start. Both pulses coincide with evt_irq.
- R9: The compare-only channel has its own settings. Address 2 holds its controls: bit 0 timer select, bits 2:1 action (same encoding as R7) and bit 3 enable. Address 3 holds its target. When enabled, it acts on pin_out and pulses cmp_irq on a match. When disabled, it leaves both untouched.
- R10: When both channels act on pin_out in the same cycle, the main channel's action is applied first and the compare-only channel's action second. Two toggles leave the pin unchanged, and in a set/clear pair the compare-only action decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe (a read of address 1 has a side effect) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| tmr_a | input | 16 | Count of timer A |
| tmr_b | input | 16 | Count of timer B |
| cap_in | input | 1 | Asynchronous capture input pin |
| pin_out | output | 1 | Shared event output pin |
| evt_irq | output | 1 | Channel event pulse |
| ovr_irq | output | 1 | Capture overrun pulse |
| cmp_irq | output | 1 | Compare-only channel match pulse |
| adc_start | output | 1 | A/D start request pulse |
| tmr_rst | output | 2 | Timer clear request pulse, one bit per timer |

## Verification
The assertions check the following on every cycle:
- The buffer is never full while the time register is empty.
- Both stages are still full after an overrun.
- A read that pops the buffer empties it.
- A match strobe never lasts two cycles.
- Two toggles leave the pin unchanged, and the compare-only channel's set or clear always decides the pin.
- Timer clear requests stay one-hot, and an A/D start never appears without an event pulse.

The bench scenarios cover what the assertions cannot:
- The captured values and which edge types are accepted.
- The order in which buffered values come out.
- Whether an overrun discards or replaces the buffered value.
- The timer selection.
- The effect of a disabled compare-only channel on the pin.

// File: rtl/evch_pkg.sv
// Package: shared types for the capture/compare event channel.
// Assumes a 7-bit channel control word and a 4-bit compare-only control word.
package evch_pkg;

    typedef enum logic [1:0] {
        PA_NONE = 2'b00,
        PA_SET  = 2'b01,
        PA_CLR  = 2'b10,
        PA_TGL  = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Channel control: bit0 timer, bit1 compare mode, bits3:2 edge/action,
    // bit4 overwrite, bit5 timer clear on match, bit6 A/D start on match.
    typedef struct packed {
        logic       adc_go;
        logic       tmr_clr;
        logic       ovw;
        logic [1:0] sub;
        logic       cmp_mode;
        logic       tsel;
    } ch_ctrl_t;

    // Compare-only control: bit0 timer, bits2:1 action, bit3 enable.
    typedef struct packed {
        logic     en;
        pin_act_e act;
        logic     tsel;
    } co_ctrl_t;

    localparam int CH_CTRL_W = $bits(ch_ctrl_t);
    localparam int CO_CTRL_W = $bits(co_ctrl_t);

    // Apply one pin action to a current pin level.
    function automatic logic pin_apply(logic cur, pin_act_e a);
        logic nxt;
        unique case (a)
            PA_SET:  nxt = 1'b1;
            PA_CLR:  nxt = 1'b0;
            PA_TGL:  nxt = ~cur;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/evch_edge.sv
// Module: evch_edge
// Synchronizes an asynchronous input through SYNC_STAGES flops and flags
// the selected edge type for one cycle. Assumes SYNC_STAGES >= 2.
module evch_edge
    import evch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      din,
    input  edge_sel_e sel,
    output logic      ev
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;
    logic                   rise;
    logic                   fall;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign cur = sync_q[SYNC_STAGES-1];

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    assign rise = cur & ~prev_q;
    assign fall = ~cur & prev_q;

    // Pick the edges that the selection accepts.
    always_comb begin
        unique case (sel)
            EDGE_FALL: ev = fall;
            EDGE_RISE: ev = rise;
            EDGE_BOTH: ev = rise | fall;
            default:   ev = 1'b0;
        endcase
    end
endmodule

// File: rtl/evch_capbuf.sv
// Module: evch_capbuf
// Owns the shared time register and the one-deep capture buffer.
// Within one cycle it applies a read pop first, then a capture, then a
// software write to the time register (the write wins on the value).
module evch_capbuf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_ev,
    input  logic [W-1:0] cap_val,
    input  logic         ovw,
    input  logic         wr_time,
    input  logic [W-1:0] wr_val,
    input  logic         rd_pop,
    output logic [W-1:0] time_q,
    output logic         ovr
);
    logic [W-1:0] buf_q;
    logic         time_full;
    logic         buf_full;
    logic [W-1:0] time_n;
    logic [W-1:0] buf_n;
    logic         tf_n;
    logic         bf_n;

    // Compute the next register, buffer and flag state.
    always_comb begin
        time_n = time_q;
        buf_n  = buf_q;
        tf_n   = time_full;
        bf_n   = buf_full;
        ovr    = 1'b0;
        if (rd_pop) begin
            if (bf_n) begin
                time_n = buf_n;
                bf_n   = 1'b0;
            end else begin
                tf_n = 1'b0;
            end
        end
        if (cap_ev) begin
            if (!tf_n) begin
                time_n = cap_val;
                tf_n   = 1'b1;
            end else if (!bf_n) begin
                buf_n = cap_val;
                bf_n  = 1'b1;
            end else begin
                ovr = 1'b1;
                if (ovw) buf_n = cap_val;
            end
        end
        if (wr_time) time_n = wr_val;
    end

    // Register the storage state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q    <= '0;
            buf_q     <= '0;
            time_full <= 1'b0;
            buf_full  <= 1'b0;
        end else begin
            time_q    <= time_n;
            buf_q     <= buf_n;
            time_full <= tf_n;
            buf_full  <= bf_n;
        end
    end

    assert_buf_needs_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> time_full);

    assert_pop_frees_buf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && !cap_ev && buf_full) |=> !buf_full);

    assert_ovr_stays_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> (time_full && buf_full));
endmodule

// File: rtl/evch_match.sv
// Module: evch_match
// Flags a match in the first cycle a timer equals a target while enabled.
// Equality history is tracked even when disabled, so enabling the match
// with the timer already sitting on the target does not fire.
module evch_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] tmr,
    input  logic [W-1:0] tgt,
    output logic         hit
);
    logic eq;
    logic eq_q;

    assign eq = (tmr == tgt);

    // Remember whether the timer sat on the target last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b1;
        else        eq_q <= eq;
    end

    assign hit = en & eq & ~eq_q;

    assert_hit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/evch_pin.sv
// Module: evch_pin
// Holds the shared output pin. Applies the main channel's action first
// and then the compare-only channel's action in the same cycle.
module evch_pin
    import evch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_act_e act_main,
    input  pin_act_e act_co,
    output logic     pin_q
);
    logic pin_n;

    // Chain the two actions in fixed order.
    always_comb begin
        pin_n = pin_apply(pin_apply(pin_q, act_main), act_co);
    end

    // Register the pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_n;
    end

    assert_two_toggles_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_main == PA_TGL && act_co == PA_TGL) |=> $stable(pin_q));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_main == PA_NONE && act_co == PA_NONE) |=> $stable(pin_q));

    assert_co_set_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_co == PA_SET) |=> pin_q);

    assert_co_clr_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_co == PA_CLR) |=> !pin_q);
endmodule

// File: rtl/evch_top.sv
// Module: evch_top
// One capture/compare event channel plus a compare-only channel sharing
// one output pin. Registers: 0 channel control, 1 channel time,
// 2 compare-only control, 3 compare-only time. Reads are combinational;
// a read of address 1 in capture mode pops the capture buffer.
// Assumes the timers are free-running counters outside this block.
module evch_top
    import evch_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] tmr_a,
    input  logic [W-1:0] tmr_b,
    input  logic         cap_in,
    output logic         pin_out,
    output logic         evt_irq,
    output logic         ovr_irq,
    output logic         cmp_irq,
    output logic         adc_start,
    output logic [1:0]   tmr_rst
);
    localparam int NTMR = 2;

    ch_ctrl_t     ctrl_q;
    co_ctrl_t     co_ctrl_q;
    logic [W-1:0] co_time_q;
    logic [W-1:0] time_q;
    logic [W-1:0] tmr_arr [NTMR];
    logic [W-1:0] main_tmr;
    logic [W-1:0] co_tmr;
    logic         edge_ev;
    logic         cap_ev;
    logic         rd_pop;
    logic         ovr;
    logic         main_hit;
    logic         co_hit;
    pin_act_e     act_main;
    pin_act_e     act_co;

    assign tmr_arr[0] = tmr_a;
    assign tmr_arr[1] = tmr_b;
    assign main_tmr   = tmr_arr[ctrl_q.tsel];
    assign co_tmr     = tmr_arr[co_ctrl_q.tsel];

    // Hold the control and compare-only target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            co_ctrl_q <= '0;
            co_time_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                2'd0:    ctrl_q    <= ch_ctrl_t'(wr_data[CH_CTRL_W-1:0]);
                2'd2:    co_ctrl_q <= co_ctrl_t'(wr_data[CO_CTRL_W-1:0]);
                2'd3:    co_time_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Return the addressed register.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            2'd0:    rd_data[CH_CTRL_W-1:0] = ctrl_q;
            2'd1:    rd_data = time_q;
            2'd2:    rd_data[CO_CTRL_W-1:0] = co_ctrl_q;
            default: rd_data = co_time_q;
        endcase
    end

    evch_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_in),
        .sel   (edge_sel_e'(ctrl_q.sub)),
        .ev    (edge_ev)
    );

    assign cap_ev = edge_ev & ~ctrl_q.cmp_mode;
    assign rd_pop = rd_en & (rd_addr == 2'd1) & ~ctrl_q.cmp_mode;

    evch_capbuf #(.W(W)) u_capbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_ev  (cap_ev),
        .cap_val (main_tmr),
        .ovw     (ctrl_q.ovw),
        .wr_time (wr_en && wr_addr == 2'd1),
        .wr_val  (wr_data),
        .rd_pop  (rd_pop),
        .time_q  (time_q),
        .ovr     (ovr)
    );

    evch_match #(.W(W)) u_match_main (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl_q.cmp_mode),
        .tmr   (main_tmr),
        .tgt   (time_q),
        .hit   (main_hit)
    );

    evch_match #(.W(W)) u_match_co (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (co_ctrl_q.en),
        .tmr   (co_tmr),
        .tgt   (co_time_q),
        .hit   (co_hit)
    );

    assign act_main = main_hit ? pin_act_e'(ctrl_q.sub) : PA_NONE;
    assign act_co   = co_hit   ? co_ctrl_q.act          : PA_NONE;

    evch_pin u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_main (act_main),
        .act_co   (act_co),
        .pin_q    (pin_out)
    );

    // Register the single-cycle event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_irq   <= 1'b0;
            ovr_irq   <= 1'b0;
            cmp_irq   <= 1'b0;
            adc_start <= 1'b0;
        end else begin
            evt_irq   <= cap_ev | main_hit;
            ovr_irq   <= ovr;
            cmp_irq   <= co_hit;
            adc_start <= main_hit & ctrl_q.adc_go;
        end
    end

    // One timer-clear request flop per timer.
    for (genvar t = 0; t < NTMR; t++) begin : g_trst
        // Pulse the clear request of the timer the channel is using.
        always_ff @(posedge clk) begin
            if (!rst_n) tmr_rst[t] <= 1'b0;
            else        tmr_rst[t] <= main_hit & ctrl_q.tmr_clr & (ctrl_q.tsel == t[0]);
        end
    end

    assert_trst_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_rst));

    assert_adc_with_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> evt_irq);
endmodule

// File: tb/tb_evch_top.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops
// each one and compares it with the live outputs mid-cycle.
module tb_evch_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic [W-1:0] tmr_a = '0;
    logic [W-1:0] tmr_b = '0;
    logic         cap_in = 1'b0;
    logic         pin_out;
    logic         evt_irq, ovr_irq, cmp_irq, adc_start;
    logic [1:0]   tmr_rst;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Kinds: 0 rd_data, 1 pin_out, 2 strobes {tmr_rst[1],tmr_rst[0],adc,cmp,ovr,evt}
    typedef struct {
        int           kind;
        logic [W-1:0] exp;
        string        req;
    } sb_item_t;
    sb_item_t sbq[$];

    evch_top #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .cap_in(cap_in),
        .pin_out(pin_out), .evt_irq(evt_irq), .ovr_irq(ovr_irq),
        .cmp_irq(cmp_irq), .adc_start(adc_start), .tmr_rst(tmr_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pop expected items and compare with the outputs.
    initial begin
        forever begin
            sb_item_t it;
            logic [W-1:0] act;
            wait (sbq.size() != 0);
            it = sbq.pop_front();
            case (it.kind)
                0:       act = rd_data;
                1:       act = {{(W-1){1'b0}}, pin_out};
                default: act = {{(W-6){1'b0}}, tmr_rst, adc_start, cmp_irq, ovr_irq, evt_irq};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    task automatic expect_item(int kind, logic [W-1:0] exp, string req);
        sbq.push_back('{kind, exp, req});
        #1;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [W-1:0] exp, string req);
        rd_addr = a; rd_en = 1'b1;
        expect_item(0, exp, req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Change the capture input and check the strobes three edges later.
    task automatic cap_chk(logic lvl, logic [W-1:0] stb, string req);
        cap_in = lvl;
        step(3);
        expect_item(2, stb, req);
        step(1);
    endtask

    task automatic neutral();
        tmr_a = 16'hFFF0; tmr_b = 16'hFFF1;
        step(1);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tmr_a = 16'h1234; tmr_b = 16'h5555;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        expect_item(1, 16'h0, "R1 pin after reset");
        expect_item(2, 16'h0, "R1 strobes after reset");
        rd_chk(2'd0, 16'h0, "R1 ctrl after reset");
        rd_chk(2'd2, 16'h0, "R1 co ctrl after reset");
        rd_chk(2'd3, 16'h0, "R1 co time after reset");

        // R3 rising capture from timer A (R2)
        wr(2'd0, 16'h0008);
        rd_chk(2'd0, 16'h0008, "R1 ctrl readback");
        cap_chk(1'b1, 16'h0001, "R3 rising edge evt");
        rd_chk(2'd1, 16'h1234, "R2 capture timer A");
        cap_chk(1'b0, 16'h0000, "R3 falling edge ignored");
        rd_chk(2'd1, 16'h1234, "R3 time unchanged by ignored edge");

        // R2 falling capture from timer B
        wr(2'd0, 16'h0005);
        cap_chk(1'b1, 16'h0000, "R3 rising ignored in falling mode");
        cap_chk(1'b0, 16'h0001, "R6 falling edge evt");
        rd_chk(2'd1, 16'h5555, "R2 capture timer B");

        // R5 both edges, overrun discards
        wr(2'd0, 16'h000C);
        tmr_a = 16'h0100; cap_chk(1'b1, 16'h0001, "R4 first capture");
        tmr_a = 16'h0200; cap_chk(1'b0, 16'h0001, "R4 buffered capture");
        tmr_a = 16'h0300; cap_chk(1'b1, 16'h0003, "R5 overrun strobe");
        rd_chk(2'd1, 16'h0100, "R4 read oldest");
        rd_chk(2'd1, 16'h0200, "R5 discard keeps buffered");

        // R5 overrun with overwrite
        wr(2'd0, 16'h001C);
        tmr_a = 16'h0400; cap_chk(1'b0, 16'h0001, "R4 capture");
        tmr_a = 16'h0500; cap_chk(1'b1, 16'h0001, "R4 buffer");
        tmr_a = 16'h0600; cap_chk(1'b0, 16'h0003, "R5 overrun overwrite strobe");
        rd_chk(2'd1, 16'h0400, "R4 read first");
        rd_chk(2'd1, 16'h0600, "R5 overwrite replaced buffer");

        // R7 compare set on timer A
        neutral();
        wr(2'd1, 16'h0040);
        wr(2'd0, 16'h0006);
        tmr_a = 16'h0040; step(1);
        expect_item(1, 16'h1, "R7 set action");
        expect_item(2, 16'h0001, "R6 compare evt");
        step(1);
        expect_item(2, 16'h0000, "R6 single pulse");
        expect_item(1, 16'h1, "R7 pin held");

        // R8 clear with timer clear and A/D start on timer B
        neutral();
        wr(2'd1, 16'h0080);
        wr(2'd0, 16'h006B);
        rd_chk(2'd0, 16'h006B, "R1 ctrl readback full");
        tmr_b = 16'h0080; step(1);
        expect_item(1, 16'h0, "R7 clear action");
        expect_item(2, 16'h0029, "R8 timer B clear and adc");
        step(1);
        expect_item(2, 16'h0000, "R8 pulses end");

        // R7 toggle, none, re-entry
        neutral();
        wr(2'd1, 16'h0010);
        wr(2'd0, 16'h000E);
        tmr_a = 16'h0010; step(1);
        expect_item(1, 16'h1, "R7 toggle up");
        tmr_a = 16'h0011; step(1);
        wr(2'd0, 16'h0002);
        tmr_a = 16'h0010; step(1);
        expect_item(2, 16'h0001, "R7 none action evt");
        expect_item(1, 16'h1, "R7 none action keeps pin");
        tmr_a = 16'h0011; step(1);
        wr(2'd0, 16'h000E);
        tmr_a = 16'h0010; step(1);
        expect_item(1, 16'h0, "R7 re-entry toggles");
        step(1);
        expect_item(1, 16'h0, "R7 no fire while held");

        // R9 compare-only channel
        neutral();
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0700);
        wr(2'd2, 16'h000A);
        rd_chk(2'd2, 16'h000A, "R9 co ctrl readback");
        rd_chk(2'd3, 16'h0700, "R9 co time readback");
        tmr_a = 16'h0700; step(1);
        expect_item(1, 16'h1, "R9 co set");
        expect_item(2, 16'h0004, "R9 co strobe");
        neutral();
        wr(2'd2, 16'h0004);
        tmr_a = 16'h0700; step(1);
        expect_item(1, 16'h1, "R9 disabled co no pin change");
        expect_item(2, 16'h0000, "R9 disabled co no strobe");

        // R10 same-cycle ordering
        neutral();
        wr(2'd1, 16'h0900);
        wr(2'd0, 16'h000E);
        wr(2'd3, 16'h0900);
        wr(2'd2, 16'h000F);
        tmr_a = 16'h0900; tmr_b = 16'h0900; step(1);
        expect_item(1, 16'h1, "R10 two toggles cancel");
        expect_item(2, 16'h0005, "R10 both strobes");
        neutral();
        wr(2'd0, 16'h0006);
        wr(2'd2, 16'h000D);
        tmr_a = 16'h0900; tmr_b = 16'h0900; step(1);
        expect_item(1, 16'h0, "R10 set then clear gives clear");
        neutral();
        wr(2'd0, 16'h000A);
        wr(2'd2, 16'h000B);
        tmr_a = 16'h0900; tmr_b = 16'h0900; step(1);
        expect_item(1, 16'h1, "R10 clear then set gives set");

        step(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule